// File: doc/BRIEF.md
# Paged Address Map with Access Rights

This block sits between address generation and the memory port. It turns a 17-bit virtual word address into a real word address. The upper 8 bits of the address select one of 256 page entries. Each entry holds an 8-bit real page number. The lower 9 bits give the word position inside a 512-word page and pass through untouched. A mode input switches translation off, and the virtual address then goes out unchanged.

Beside the page table sits a 2-bit rights code for every virtual page. When the requester runs unprivileged, each access is tested against the code of its virtual page. An access that is not allowed raises a trap instead of a memory request. The trap carries the offending virtual page and access type.

A single configuration write port loads both stores. The result of a lookup appears one clock after the request.

Top module: `page_map`

## Requirements
- R1: After reset, `mem_valid_o` and `trap_o` are low. Every page entry maps page i to real page i. Every rights code is 00.
- R2: A request presented at a clock edge produces its result after exactly one further edge. For each request, exactly one of `mem_valid_o` and `trap_o` is high. Both are low in a cycle that follows no request.
- R3: With `map_en_i` high, `raddr_o` is the real page stored for the virtual page, followed by the unchanged 9-bit word offset.
- R4: With `map_en_i` low, `raddr_o` equals `vaddr_i`.
- R5: The access type is encoded as 00 fetch, 01 read and 10 write; 11 is treated as a write. For an unprivileged request, code 00 allows every type. Code 01 rejects only writes.
- R6: For an unprivileged request, code 10 allows only reads. Code 11 rejects every type.
- R7: A request with `priv_i` high never traps, whatever the rights code.
- R8: A rejected request raises `trap_o`, keeps `mem_valid_o` low, and reports the virtual page on `trap_page_o` and the type on `trap_type_o`. Both report fields are zero in cycles without a trap.
- R9: A configuration write with `cfg_sel_i`=0 stores `cfg_data_i` as the real page of entry `cfg_idx_i`. With `cfg_sel_i`=1 it stores `cfg_data_i[1:0]` as that page's rights code. A request in the same cycle as the write still sees the old contents; the new value applies from the next cycle.
- R10: The rights check uses the virtual page, both when translation is on and when it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| vaddr_i | input | 17 | Virtual word address |
| acc_type_i | input | 2 | Access type: 00 fetch, 01 read, 10/11 write |
| priv_i | input | 1 | High when the requester is privileged |
| map_en_i | input | 1 | Translation enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the page table, 1 selects the rights codes |
| cfg_idx_i | input | 8 | Page index to write |
| cfg_data_i | input | 8 | Real page, or rights code in bits 1:0 |
| mem_valid_o | output | 1 | Accepted memory request |
| raddr_o | output | 17 | Real word address of the accepted request |
| trap_o | output | 1 | Access violation |
| trap_page_o | output | 8 | Virtual page of the violation |
| trap_type_o | output | 2 | Access type of the violation |

## Verification
Random addresses, types, privilege levels and mode settings run over tables that are rewritten at random. These runs separate translated paths from untranslated ones and reveal stale or misindexed entries. Directed sweeps of all four rights codes against all four access types, in both privilege states, pin down the permission matrix. One directed case sets the real page and the virtual page to different rights codes. It shows whether the check indexes by the virtual page. A write and a request in the same cycle show whether the update lands one cycle later rather than flowing through combinationally.

// File: rtl/page_map_pkg.sv
package page_map_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_WRX   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RT_OPEN   = 2'b00,
    RT_NOWR   = 2'b01,
    RT_RDONLY = 2'b10,
    RT_NONE   = 2'b11
  } rights_e;

  localparam int unsigned RIGHTS_W = 2;
endpackage

// File: rtl/pm_table.sv
module pm_table #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter bit          ID_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [DATA_W-1:0] RST_VAL = ID_RST ? DATA_W'(g) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= RST_VAL;
      else if (we_i && widx_i == IDX_W'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/pm_rights_check.sv
module pm_rights_check
  import page_map_pkg::*;
(
  input  logic [1:0] code_i,
  input  logic [1:0] type_i,
  output logic       deny_o
);
  logic is_fetch, is_read, is_write;

  assign is_fetch = (type_i == ACC_FETCH);
  assign is_read  = (type_i == ACC_READ);
  assign is_write = !is_fetch && !is_read;

  always_comb begin
    unique case (rights_e'(code_i))
      RT_OPEN:   deny_o = 1'b0;
      RT_NOWR:   deny_o = is_write;
      RT_RDONLY: deny_o = !is_read;
      default:   deny_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/page_map.sv
module page_map
  import page_map_pkg::*;
#(
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned OFS_W   = 9,
  parameter int unsigned RPAGE_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [PAGE_W+OFS_W-1:0]    vaddr_i,
  input  logic [1:0]                 acc_type_i,
  input  logic                       priv_i,
  input  logic                       map_en_i,
  input  logic                       cfg_we_i,
  input  logic                       cfg_sel_i,
  input  logic [PAGE_W-1:0]          cfg_idx_i,
  input  logic [RPAGE_W-1:0]         cfg_data_i,
  output logic                       mem_valid_o,
  output logic [RPAGE_W+OFS_W-1:0]   raddr_o,
  output logic                       trap_o,
  output logic [PAGE_W-1:0]          trap_page_o,
  output logic [1:0]                 trap_type_o
);
  localparam int unsigned VA_W = PAGE_W + OFS_W;
  localparam int unsigned RA_W = RPAGE_W + OFS_W;

  logic [PAGE_W-1:0]   vpage;
  logic [OFS_W-1:0]    vofs;
  logic [RPAGE_W-1:0]  rpage;
  logic [RIGHTS_W-1:0] code;
  logic                deny, viol, accept;
  logic [RA_W-1:0]     xlat;

  assign vpage = vaddr_i[VA_W-1:OFS_W];
  assign vofs  = vaddr_i[OFS_W-1:0];

  pm_table #(.IDX_W(PAGE_W), .DATA_W(RPAGE_W), .ID_RST(1'b1)) u_map (
    .clk_i, .rst_ni,
    .we_i   (cfg_we_i && !cfg_sel_i),
    .widx_i (cfg_idx_i),
    .wdata_i(cfg_data_i),
    .ridx_i (vpage),
    .rdata_o(rpage)
  );

  pm_table #(.IDX_W(PAGE_W), .DATA_W(RIGHTS_W), .ID_RST(1'b0)) u_rights (
    .clk_i, .rst_ni,
    .we_i   (cfg_we_i && cfg_sel_i),
    .widx_i (cfg_idx_i),
    .wdata_i(cfg_data_i[RIGHTS_W-1:0]),
    .ridx_i (vpage),
    .rdata_o(code)
  );

  pm_rights_check u_chk (
    .code_i(code),
    .type_i(acc_type_i),
    .deny_o(deny)
  );

  assign viol   = req_valid_i && !priv_i && deny;
  assign accept = req_valid_i && !viol;
  assign xlat   = map_en_i ? {rpage, vofs} : RA_W'(vaddr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid_o <= 1'b0;
      trap_o      <= 1'b0;
      raddr_o     <= '0;
      trap_page_o <= '0;
      trap_type_o <= '0;
    end else begin
      mem_valid_o <= accept;
      trap_o      <= viol;
      if (accept) raddr_o <= xlat;
      trap_page_o <= viol ? vpage : '0;
      trap_type_o <= viol ? acc_type_i : '0;
    end
  end

  a_r2_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (mem_valid_o ^ trap_o));
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!mem_valid_o && !trap_o));
  a_r7_priv_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i) |=> !trap_o);
  a_r3_ofs_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (trap_o || raddr_o[OFS_W-1:0] == $past(vofs)));
  a_r4_flat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !map_en_i) |=> (trap_o || raddr_o == RA_W'($past(vaddr_i))));
  a_r8_trap_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!trap_o || trap_page_o == $past(vpage)));
  a_r8_quiet_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (trap_page_o == '0 && trap_type_o == '0));
endmodule

// File: tb/sim_page_map.sv
`timescale 1ns/1ps
module sim_page_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [16:0] vaddr = '0;
  logic [1:0]  acc_type = '0;
  logic        priv = 1'b0;
  logic        map_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_idx = '0;
  logic [7:0]  cfg_data = '0;
  logic        mem_valid, trap;
  logic [16:0] raddr;
  logic [7:0]  trap_page;
  logic [1:0]  trap_type;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_map  [256];
  logic [1:0] m_code [256];

  always #2.5 clk = ~clk;

  page_map u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .vaddr_i(vaddr),
    .acc_type_i(acc_type), .priv_i(priv), .map_en_i(map_en),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .mem_valid_o(mem_valid), .raddr_o(raddr), .trap_o(trap),
    .trap_page_o(trap_page), .trap_type_o(trap_type)
  );

  function automatic bit exp_deny(logic [1:0] code, logic [1:0] t);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return t[1];
      2'b10:   return t != 2'b01;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives one cycle at a negedge, checks at the following negedge
  task automatic cycle(bit rv, logic [16:0] va, logic [1:0] t, bit pr, bit me,
                       bit we, bit sel, logic [7:0] idx, logic [7:0] dat);
    bit          e_trap;
    logic [16:0] e_ra;
    logic [7:0]  vp;
    vp     = va[16:9];
    e_trap = rv && !pr && exp_deny(m_code[vp], t);
    e_ra   = me ? {m_map[vp], va[8:0]} : va;
    req_valid = rv; vaddr = va; acc_type = t; priv = pr; map_en = me;
    cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_data = dat;
    @(negedge clk);
    if (we) begin
      if (sel) m_code[idx] = dat[1:0];
      else     m_map[idx]  = dat;
    end
    req_valid = 1'b0; cfg_we = 1'b0;
    if (rv) begin
      chk(pr ? "R7 trap" : (m_code[vp] < 2 ? "R5 trap" : "R6 trap"), 32'(trap), 32'(e_trap));
      chk("R2 mem_valid", 32'(mem_valid), 32'(!e_trap));
      if (!e_trap) chk(me ? "R3 raddr" : "R4 raddr", 32'(raddr), 32'(e_ra));
      chk("R8 trap_page", 32'(trap_page), e_trap ? 32'(vp) : 32'h0);
      chk("R8 trap_type", 32'(trap_type), e_trap ? 32'(t) : 32'h0);
    end else begin
      chk("R2 idle", 32'({mem_valid, trap}), 32'h0);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_map[i] = 8'(i); m_code[i] = 2'b00; end
    void'($urandom(32'd1966));
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", 32'({mem_valid, trap, trap_page, trap_type}), 32'h0);
    // R1: identity map and open rights after reset
    cycle(1, 17'h1ABCD, 2'b10, 0, 1, 0, 0, 0, 0);
    cycle(1, 17'h0F00F, 2'b00, 0, 1, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5/R6/R7: full rights matrix on page 3
    for (int c = 0; c < 4; c++) begin
      cycle(0, 0, 0, 0, 0, 1, 1, 8'd3, 8'(c));
      for (int t = 0; t < 4; t++) begin
        cycle(1, {8'd3, 9'h055}, 2'(t), 0, 1, 0, 0, 0, 0);
        cycle(1, {8'd3, 9'h1AA}, 2'(t), 1, 1, 0, 0, 0, 0);
      end
    end
    // R9/R10: real page differs in rights from virtual page
    cycle(0, 0, 0, 0, 0, 1, 0, 8'd5, 8'h20);
    cycle(0, 0, 0, 0, 0, 1, 1, 8'd5, 8'd3);
    cycle(0, 0, 0, 0, 0, 1, 1, 8'h20, 8'd0);
    cycle(1, {8'd5, 9'h011}, 2'b01, 0, 1, 0, 0, 0, 0);
    chk("R10 page map on", 32'(trap), 32'h1);
    cycle(1, {8'd5, 9'h011}, 2'b01, 0, 0, 0, 0, 0, 0);
    chk("R10 page map off", 32'(trap), 32'h1);
    // R9: same-cycle write sees old value, next cycle sees new
    cycle(1, {8'd9, 9'h123}, 2'b01, 0, 1, 1, 0, 8'd9, 8'hC4);
    chk("R9 old entry", 32'(raddr), 32'({8'd9, 9'h123}));
    cycle(1, {8'd9, 9'h123}, 2'b01, 0, 1, 0, 0, 0, 0);
    chk("R9 new entry", 32'(raddr), 32'({8'hC4, 9'h123}));
    cycle(1, {8'd9, 9'h000}, 2'b10, 0, 0, 1, 1, 8'd9, 8'd2);
    chk("R9 old code", 32'(trap), 32'h0);
    cycle(1, {8'd9, 9'h000}, 2'b10, 0, 0, 0, 0, 0, 0);
    chk("R9 new code", 32'(trap), 32'h1);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      cycle(($urandom % 8) != 0, 17'($urandom), 2'($urandom), ($urandom % 4) == 0,
            ($urandom % 4) != 0, ($urandom % 5) == 0, 1'($urandom),
            8'($urandom % 16), 8'($urandom));
    end
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule